// File: doc/BRIEF.md
# GCR Telemetry Word Decoder

This block converts one raw 21-bit telemetry word into a timing value. The word comes from the return path of a bidirectional motor-control line, after an upstream sampler has already recovered its bits. The input word carries transitions rather than levels. The decoder first turns those transitions back into levels. It then cuts the level word into four 5-bit group-coded symbols and maps each symbol to a 4-bit nibble. The lowest nibble is a checksum, and the decoder verifies it against the other three. The remaining 12 bits hold a value in exponent/mantissa form, which the decoder expands into a plain period value.

A producer presents a word on `code_in` together with a one-cycle `code_vld` strobe. One clock later the block raises `out_vld` for one cycle. In that cycle `period_out` and `err_out` carry the result. Both outputs then hold until the next strobe. Converting the period into a rotational speed is left to whatever consumes the result.

Top module: `telem_word_decoder`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_vld`, `err_out` and `period_out` are all zero, even if `code_vld` is high during reset.
- R2: Each cycle with `code_vld` high produces exactly one cycle of `out_vld` high on the next clock edge. `out_vld` is never high in a cycle that does not follow a strobe. Back-to-back strobes produce back-to-back result cycles.
- R3: The level word is `code_in ^ (code_in >> 1)`, with zero shifted into bit 20. Symbol k (k = 0..3) is level bits [5k+4:5k]. Input bit 20 therefore affects the result only through level bit 19.
- R4: The symbol-to-nibble mapping is: 0x19→0, 0x1B→1, 0x12→2, 0x13→3, 0x1D→4, 0x15→5, 0x16→6, 0x17→7, 0x1A→8, 0x09→9, 0x0A→A, 0x0B→B, 0x1E→C, 0x0D→D, 0x0E→E, 0x0F→F.
- R5: A 5-bit symbol that does not appear in the R4 mapping, in any of the four positions, sets `err_out` to 1 and `period_out` to 0.
- R6: With nibbles n0 (symbol 0) through n3, the word is accepted only if n0 equals the low four bits of ~(n1 ^ n2 ^ n3). Otherwise `err_out` is 1 and `period_out` is 0.
- R7: For an accepted word, the data value is {n3, n2, n1}. Its bits [11:9] are an exponent e and bits [8:0] are a mantissa m. `period_out` = m << e as a 16-bit value (saturating if a narrower output is configured), and `err_out` is 0.
- R8: In a cycle with `code_vld` low, `period_out` and `err_out` keep their previous values on the next edge, whatever `code_in` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_vld | input | 1 | Strobe: `code_in` holds a word this cycle |
| code_in | input | 21 | Raw transition-coded telemetry word |
| out_vld | output | 1 | One-cycle pulse: a result is present |
| period_out | output | 16 | Expanded period value, zero on error |
| err_out | output | 1 | Invalid symbol or checksum mismatch |

## Verification
Every result is due exactly one clock after the strobe that carried its word, because the block has a single register stage. The bench keeps a behavioural model that captures the word at the same edge the design does and forms the expected value for the following cycle. The model and the design outputs are compared at every falling edge, so the check always looks at settled values. In idle cycles the model expects the previous value to hold, which also covers the timing of R8.

// File: rtl/telem_pkg.sv
package telem_pkg;

    localparam int CODE_W     = 21;
    localparam int SYM_W      = 5;
    localparam int NIB_W      = 4;
    localparam int NUM_SYM    = 4;
    localparam int DATA_W     = NIB_W * (NUM_SYM - 1);
    localparam int EXP_W      = 3;
    localparam int MANT_W     = DATA_W - EXP_W;
    localparam int WIDE_W     = MANT_W + (1 << EXP_W) - 1;
    localparam int PERIOD_DEF = 16;

    typedef logic [SYM_W-1:0] sym_t;
    typedef logic [NIB_W-1:0] nib_t;

    typedef struct packed {
        nib_t nib;
        logic bad;
    } sym_dec_t;

    typedef struct packed {
        logic [EXP_W-1:0]  expo;
        logic [MANT_W-1:0] mant;
    } float_word_t;

    function automatic sym_dec_t gcr_decode(input sym_t s);
        sym_dec_t r;
        r.bad = 1'b0;
        r.nib = '0;
        case (s)
            5'h19: r.nib = 4'h0;
            5'h1B: r.nib = 4'h1;
            5'h12: r.nib = 4'h2;
            5'h13: r.nib = 4'h3;
            5'h1D: r.nib = 4'h4;
            5'h15: r.nib = 4'h5;
            5'h16: r.nib = 4'h6;
            5'h17: r.nib = 4'h7;
            5'h1A: r.nib = 4'h8;
            5'h09: r.nib = 4'h9;
            5'h0A: r.nib = 4'hA;
            5'h0B: r.nib = 4'hB;
            5'h1E: r.nib = 4'hC;
            5'h0D: r.nib = 4'hD;
            5'h0E: r.nib = 4'hE;
            5'h0F: r.nib = 4'hF;
            default: r.bad = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tl_level_unxor.sv
module tl_level_unxor
    import telem_pkg::*;
#(
    parameter int W = CODE_W
) (
    input  logic [W-1:0] trans_word,
    output logic [W-1:0] level_word
);
    always_comb begin
        level_word = trans_word ^ (trans_word >> 1);
    end
endmodule

// File: rtl/tl_gcr_symbol.sv
module tl_gcr_symbol
    import telem_pkg::*;
(
    input  sym_t sym,
    output nib_t nib,
    output logic bad
);
    sym_dec_t dec;
    always_comb begin
        dec = gcr_decode(sym);
        nib = dec.nib;
        bad = dec.bad;
    end
endmodule

// File: rtl/tl_check_expand.sv
module tl_check_expand
    import telem_pkg::*;
#(
    parameter int PERIOD_W = PERIOD_DEF
) (
    input  logic [NUM_SYM-1:0][NIB_W-1:0] nibs,
    input  logic [NUM_SYM-1:0]            bad,
    output logic [PERIOD_W-1:0]           period,
    output logic                          err
);
    nib_t             csum_exp;
    logic             csum_bad;
    float_word_t      fw;
    logic [WIDE_W-1:0] wide;
    logic [PERIOD_W-1:0] sized;

    always_comb begin
        csum_exp = ~(nibs[1] ^ nibs[2] ^ nibs[3]);
        csum_bad = (csum_exp != nibs[0]);
        fw       = {nibs[3], nibs[2], nibs[1]};
        wide     = WIDE_W'(fw.mant) << fw.expo;
        err      = (|bad) | csum_bad;
    end

    generate
        if (PERIOD_W >= WIDE_W) begin : g_fit
            always_comb sized = PERIOD_W'(wide);
        end else begin : g_sat
            always_comb begin
                if (|wide[WIDE_W-1:PERIOD_W])
                    sized = '1;
                else
                    sized = wide[PERIOD_W-1:0];
            end
        end
    endgenerate

    always_comb begin
        period = err ? '0 : sized;
    end
endmodule

// File: rtl/telem_word_decoder.sv
module telem_word_decoder
    import telem_pkg::*;
#(
    parameter int PERIOD_W = PERIOD_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                code_vld,
    input  logic [CODE_W-1:0]   code_in,
    output logic                out_vld,
    output logic [PERIOD_W-1:0] period_out,
    output logic                err_out
);
    logic [CODE_W-1:0]             level;
    logic [NUM_SYM-1:0][NIB_W-1:0] nibs;
    logic [NUM_SYM-1:0]            sym_bad;
    logic [PERIOD_W-1:0]           period_c;
    logic                          err_c;

    tl_level_unxor #(.W(CODE_W)) u_unxor (
        .trans_word (code_in),
        .level_word (level)
    );

    for (genvar k = 0; k < NUM_SYM; k++) begin : g_sym
        tl_gcr_symbol u_sym (
            .sym (level[k*SYM_W +: SYM_W]),
            .nib (nibs[k]),
            .bad (sym_bad[k])
        );
    end

    tl_check_expand #(.PERIOD_W(PERIOD_W)) u_chk (
        .nibs   (nibs),
        .bad    (sym_bad),
        .period (period_c),
        .err    (err_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld    <= 1'b0;
            period_out <= '0;
            err_out    <= 1'b0;
        end else begin
            out_vld <= code_vld;
            if (code_vld) begin
                period_out <= period_c;
                err_out    <= err_c;
            end
        end
    end
endmodule

// File: rtl/telem_word_decoder_chk.sv
module telem_word_decoder_chk #(
    parameter int PERIOD_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                code_vld,
    input logic                out_vld,
    input logic [PERIOD_W-1:0] period_out,
    input logic                err_out
);
    assert_vld_follows_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        code_vld |=> out_vld);

    assert_vld_needs_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        !code_vld |=> !out_vld);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !code_vld |=> ($stable(period_out) && $stable(err_out)));

    assert_err_zero_period_R5: assert property (@(posedge clk) disable iff (rst)
        err_out |-> (period_out == '0));
endmodule

bind telem_word_decoder telem_word_decoder_chk #(.PERIOD_W(PERIOD_W)) u_chk_bind (
    .clk        (clk),
    .rst        (rst),
    .code_vld   (code_vld),
    .out_vld    (out_vld),
    .period_out (period_out),
    .err_out    (err_out)
);

// File: tb/telem_word_decoder_bench.sv
`timescale 1ns/1ps
module telem_word_decoder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        code_vld = 1'b0;
    logic [20:0] code_in = '0;
    logic        out_vld;
    logic [15:0] period_out;
    logic        err_out;

    int vectors = 0;
    int fails = 0;
    bit done = 0;
    bit checking = 0;
    string cur_req = "R1";

    logic        m_vld;
    logic [15:0] m_per;
    logic        m_err;

    int enc [16] = '{'h19, 'h1B, 'h12, 'h13, 'h1D, 'h15, 'h16, 'h17,
                     'h1A, 'h09, 'h0A, 'h0B, 'h1E, 'h0D, 'h0E, 'h0F};

    always #2.5 clk = ~clk;

    telem_word_decoder u_telem_word_decoder (
        .clk (clk), .rst (rst), .code_vld (code_vld), .code_in (code_in),
        .out_vld (out_vld), .period_out (period_out), .err_out (err_out)
    );

    function automatic void ref_decode(input logic [20:0] c, output logic [15:0] per,
                                       output logic er);
        int lvl, n[4], d, e, m, p;
        bit bad;
        lvl = int'(c) ^ (int'(c) >> 1);
        bad = 0;
        for (int k = 0; k < 4; k++) begin
            int s;
            bit hit;
            s = (lvl >> (5 * k)) & 31;
            hit = 0;
            n[k] = 0;
            for (int j = 0; j < 16; j++) if (enc[j] == s) begin n[k] = j; hit = 1; end
            if (!hit) bad = 1;
        end
        if (n[0] != ((~(n[1] ^ n[2] ^ n[3])) & 15)) bad = 1;
        d = n[3] * 256 + n[2] * 16 + n[1];
        e = d / 512;
        m = d % 512;
        p = m * (1 << e);
        if (p > 65535) p = 65535;
        er  = bad;
        per = bad ? 16'd0 : 16'(p);
    endfunction

    // build a code word from four symbol values; top selects input bit 20
    function automatic logic [20:0] make_code(input int s0, input int s1, input int s2,
                                              input int s3, input bit top);
        logic [20:0] lv, c;
        lv = '0;
        lv[4:0] = 5'(s0); lv[9:5] = 5'(s1); lv[14:10] = 5'(s2); lv[19:15] = 5'(s3);
        c = '0;
        c[20] = top;
        for (int i = 19; i >= 0; i--) c[i] = lv[i] ^ c[i+1];
        return c;
    endfunction

    function automatic logic [20:0] good_code(input int data, input bit top);
        int n1, n2, n3, cs;
        n1 = data & 15; n2 = (data >> 4) & 15; n3 = (data >> 8) & 15;
        cs = (~(n1 ^ n2 ^ n3)) & 15;
        return make_code(enc[cs], enc[n1], enc[n2], enc[n3], top);
    endfunction

    always @(posedge clk) begin
        logic [15:0] p;
        logic e;
        if (rst) begin
            m_vld <= 1'b0; m_per <= '0; m_err <= 1'b0;
        end else begin
            m_vld <= code_vld;
            if (code_vld) begin
                ref_decode(code_in, p, e);
                m_per <= p; m_err <= e;
            end
        end
    end

    task automatic compare();
        if (!checking) return;
        vectors++;
        if (out_vld !== m_vld || period_out !== m_per || err_out !== m_err) begin
            fails++;
            $display("FAIL %s: got vld=%0b per=%0d err=%0b, expected vld=%0b per=%0d err=%0b",
                     cur_req, out_vld, period_out, err_out, m_vld, m_per, m_err);
        end
    endtask

    task automatic step(input bit v, input logic [20:0] c);
        @(negedge clk);
        compare();
        code_vld = v;
        code_in  = c;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        // R1: strobe asserted while in reset must not leak
        code_vld = 1'b1;
        code_in  = good_code('h3FF, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        code_vld = 1'b0;
        @(negedge clk);
        vectors++;
        if (out_vld !== 1'b0 || err_out !== 1'b0 || period_out !== 16'd0) begin
            fails++;
            $display("FAIL R1: got vld=%0b per=%0d err=%0b, expected 0 0 0",
                     out_vld, period_out, err_out);
        end
        checking = 1;

        // R4: every nibble value in every position
        cur_req = "R4";
        for (int n = 0; n < 16; n++) begin
            step(1, good_code(n * 'h111, n[0]));
            step(0, '0);
        end

        // R7: every exponent with several mantissas
        cur_req = "R7";
        for (int e = 0; e < 8; e++) begin
            step(1, good_code(e * 512 + 1, 0));
            step(1, good_code(e * 512 + 511, 1));
            step(1, good_code(e * 512 + 'h155, 0));
            step(1, good_code(e * 512, 1));
        end

        // R3: bit 20 choice must not change the decoded result
        cur_req = "R3";
        for (int i = 0; i < 12; i++) begin
            step(1, good_code((i * 331 + 77) & 'hFFF, 0));
            step(1, good_code((i * 331 + 77) & 'hFFF, 1));
        end

        // R5: an invalid symbol in each position
        cur_req = "R5";
        for (int k = 0; k < 4; k++) begin
            int s[4];
            int inv[3] = '{0, 'h1F, 'h14};
            for (int b = 0; b < 3; b++) begin
                int cs;
                cs = (~(2 ^ 3 ^ 4)) & 15;
                s[0] = enc[cs]; s[1] = enc[2]; s[2] = enc[3]; s[3] = enc[4];
                s[k] = inv[b];
                step(1, make_code(s[0], s[1], s[2], s[3], 0));
                step(1, good_code('h234, 0));
            end
        end

        // R6: wrong checksum nibble (valid symbol)
        cur_req = "R6";
        for (int i = 0; i < 8; i++) begin
            int d, cs;
            d  = (i * 517 + 9) & 'hFFF;
            cs = (~((d & 15) ^ ((d >> 4) & 15) ^ ((d >> 8) & 15))) & 15;
            step(1, make_code(enc[(cs + 1 + i) & 15], enc[d & 15], enc[(d >> 4) & 15],
                              enc[(d >> 8) & 15], 0));
            step(0, '0);
        end

        // R8: idle cycles with changing input hold the last result
        cur_req = "R8";
        step(1, good_code('hA5C, 0));
        for (int i = 0; i < 6; i++) step(0, good_code(i * 100, i[0]));
        step(1, make_code(0, 0, 0, 0, 0));
        for (int i = 0; i < 4; i++) step(0, good_code('h7FF, 1));

        // R2: back-to-back strobes then isolated ones
        cur_req = "R2";
        for (int i = 0; i < 10; i++) step(1, good_code(i * 401, 0));
        for (int i = 0; i < 5; i++) begin
            step(1, good_code(i * 97, 1));
            step(0, '0);
            step(0, '0);
        end
        step(0, '0);
        step(0, '0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule